// File: doc/BRIEF.md
# Floating-Point Value Classifier

This unit sorts a single- or double-precision IEEE-754 operand into one of ten classes and reports the class as a one-hot mask. It is purely combinational: the instruction word and the operand go in, and the mask comes out in the same cycle. The instruction word is decoded in the same unit. It selects the precision and confirms that the encoding is the classify operation with its unused source-register field cleared.

The mask occupies the low ten bits of a 64-bit result, and every higher bit is zero. A single-precision operation therefore yields a value that is already zero-extended to 32 bits, and a double-precision one a value zero-extended to 64 bits. An encoding that is not a valid classify operation yields an all-zero result and a low `insn_ok`. The unit raises no exception flags.

Top module: `fp_class_unit`

## Requirements
- R1: For a valid encoding, exactly one of `result[9:0]` is set and `result[63:10]` is zero.
- R2: An operand with an all-ones exponent and a nonzero fraction is a NaN, whatever its sign. It sets bit 0 when the fraction MSB is 0 (signaling) and bit 1 when the fraction MSB is 1 (quiet).
- R3: An all-ones exponent with a zero fraction is infinity: bit 2 when the sign is 1, bit 6 when the sign is 0.
- R4: A zero exponent with a zero fraction is zero: bit 5 when the sign is 1, bit 9 when the sign is 0.
- R5: A zero exponent with a nonzero fraction is subnormal: bit 4 when the sign is 1, bit 8 when the sign is 0.
- R6: Any other value is normal: bit 3 when the sign is 1, bit 7 when the sign is 0.
- R7: Precision comes from the fmt field `insn[25:21]`. 0x10 selects single and classifies `operand[31:0]` (sign 31, exponent 30:23, fraction 22:0); the value of `operand[63:32]` then has no effect. 0x11 selects double and classifies `operand[63:0]` (sign 63, exponent 62:52, fraction 51:0).
- R8: `insn_ok` is 1 exactly when all four of these hold: `insn[31:26]` = 0x11, fmt is 0x10 or 0x11, the ft field `insn[20:16]` is zero, and the function field `insn[5:0]` is 27. Bits 15:6 have no effect.
- R9: When `insn_ok` is 0, `result` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 32 | Instruction word carrying the opcode, fmt, ft and function fields |
| operand | input | 64 | Value to classify; only the low 32 bits are used in single precision |
| result | output | 64 | One-hot class mask in bits 9:0, zero above |
| insn_ok | output | 1 | High when the encoding is a valid classify operation |

## Verification
The unit holds no state, so any fault shows up on the ports in the same cycle as the input that triggers it. A wrong precision decode moves the field boundaries. That mislabels NaN against infinity, and subnormal against normal, for operands whose two halves differ. A wrong priority in the chain lets a NaN report a sign-dependent class, or lets a zero read as subnormal. The bench drives values that sit exactly on each field boundary, and for each one it checks the full 64-bit result and the valid flag against an independent model.

// File: rtl/fp_class_unit.sv
module fp_class_unit (
  input  logic [31:0] insn,
  input  logic [63:0] operand,
  output logic [63:0] result,
  output logic        insn_ok
);
  localparam logic [5:0] MAJOR_OP = 6'h11;
  localparam logic [5:0] FUNC_CLS = 6'd27;
  localparam logic [4:0] FMT_SGL  = 5'h10;
  localparam logic [4:0] FMT_DBL  = 5'h11;
  localparam int         MASK_W   = 10;

  logic dbl;
  logic sgn, e_ones, e_zero, f_zero, f_top;
  logic [MASK_W-1:0] mask;
  logic unused_fields;

  assign dbl = (insn[25:21] == FMT_DBL);
  assign insn_ok = (insn[31:26] == MAJOR_OP) &&
                   ((insn[25:21] == FMT_SGL) || dbl) &&
                   (insn[20:16] == 5'd0) &&
                   (insn[5:0] == FUNC_CLS);
  assign unused_fields = ^insn[15:6];

  always_comb begin
    if (dbl) begin
      sgn    = operand[63];
      e_ones = &operand[62:52];
      e_zero = ~|operand[62:52];
      f_zero = ~|operand[51:0];
      f_top  = operand[51];
    end else begin
      sgn    = operand[31];
      e_ones = &operand[30:23];
      e_zero = ~|operand[30:23];
      f_zero = ~|operand[22:0];
      f_top  = operand[22];
    end
  end

  always_comb begin
    mask = '0;
    if (e_ones && !f_zero) begin
      if (f_top) mask[1] = 1'b1;
      else       mask[0] = 1'b1;
    end else if (sgn) begin
      if (e_ones)      mask[2] = 1'b1;
      else if (f_zero && e_zero) mask[5] = 1'b1;
      else if (e_zero) mask[4] = 1'b1;
      else             mask[3] = 1'b1;
    end else begin
      if (e_ones)      mask[6] = 1'b1;
      else if (f_zero && e_zero) mask[9] = 1'b1;
      else if (e_zero) mask[8] = 1'b1;
      else             mask[7] = 1'b1;
    end
  end

  assign result = insn_ok ? {{(64-MASK_W){1'b0}}, mask} : 64'd0;
endmodule

module fp_class_unit_chk (
  input logic [31:0] insn,
  input logic [63:0] operand,
  input logic [63:0] result,
  input logic        insn_ok
);
  logic known, is_dbl, nan_in, neg_in;

  always_comb begin
    known  = !$isunknown({insn, operand, result, insn_ok});
    is_dbl = insn[21];
    nan_in = is_dbl ? ((operand[62:52] == 11'h7FF) && (operand[51:0] != 52'd0))
                    : ((operand[30:23] == 8'hFF) && (operand[22:0] != 23'd0));
    neg_in = is_dbl ? operand[63] : operand[31];
    if (known && insn_ok) begin
      p_onehot_r1: assert ($countones(result[9:0]) == 1);
      p_upper_zero_r1: assert (result[63:10] == 54'd0);
      if (nan_in) begin
        p_nan_class_r2: assert (result[1:0] != 2'b00);
      end
      if (!nan_in && neg_in) begin
        p_neg_side_r3: assert (result[9:6] == 4'd0 && result[1:0] == 2'd0);
      end
      if (!nan_in && !neg_in) begin
        p_pos_side_r4: assert (result[5:0] == 6'd0);
      end
      p_ft_zero_r8: assert (insn[20:16] == 5'd0 && insn[5:0] == 6'd27);
    end
    if (known && !insn_ok) begin
      p_bad_enc_zero_r9: assert (result == 64'd0);
    end
  end
endmodule

bind fp_class_unit fp_class_unit_chk u_chk (
  .insn(insn), .operand(operand), .result(result), .insn_ok(insn_ok)
);

// File: tb/fp_class_unit_bench.sv
module fp_class_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] insn = 32'd0;
  logic [63:0] operand = 64'd0;
  logic [63:0] result;
  logic insn_ok;
  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  fp_class_unit u_fp_class_unit (
    .insn(insn), .operand(operand), .result(result), .insn_ok(insn_ok)
  );

  function automatic logic [31:0] enc(input logic [4:0] fmt, input logic [4:0] ft,
                                      input logic [9:0] mid, input logic [5:0] fn);
    return {6'h11, fmt, ft, mid, fn};
  endfunction

  function automatic logic [63:0] model(input logic [31:0] w, input logic [63:0] v);
    int idx;
    logic neg;
    logic [62:0] mag;
    logic [62:0] inf_m, qnan_m, min_norm;
    if (w[31:26] != 6'h11 || w[20:16] != 0 || w[5:0] != 27 ||
        !(w[25:21] == 5'h10 || w[25:21] == 5'h11))
      return 64'd0;
    if (w[25:21] == 5'h11) begin
      neg = v[63]; mag = v[62:0];
      inf_m = 63'h7FF0_0000_0000_0000; qnan_m = 63'h7FF8_0000_0000_0000;
      min_norm = 63'h0010_0000_0000_0000;
    end else begin
      neg = v[31]; mag = {32'd0, v[30:0]};
      inf_m = 63'h7F80_0000; qnan_m = 63'h7FC0_0000; min_norm = 63'h0080_0000;
    end
    if (mag > inf_m) idx = (mag >= qnan_m) ? 1 : 0;
    else if (mag == inf_m) idx = neg ? 2 : 6;
    else if (mag == 0) idx = neg ? 5 : 9;
    else if (mag < min_norm) idx = neg ? 4 : 8;
    else idx = neg ? 3 : 7;
    return 64'd1 << idx;
  endfunction

  task automatic apply(input logic [31:0] w, input logic [63:0] v, input string req);
    logic [63:0] exp_r;
    logic exp_ok;
    @(posedge clk);
    #1;
    insn = w; operand = v;
    exp_r = model(w, v);
    exp_ok = (w[31:26] == 6'h11) && (w[20:16] == 0) && (w[5:0] == 27) &&
             (w[25:21] == 5'h10 || w[25:21] == 5'h11);
    @(negedge clk);
    n_run++;
    if (result !== exp_r || insn_ok !== exp_ok) begin
      n_fail++;
      $display("FAIL %s insn=%h op=%h actual=%h/%b expected=%h/%b",
               req, w, v, result, insn_ok, exp_r, exp_ok);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] s_ins, d_ins;
    s_ins = enc(5'h10, 5'd0, 10'h155, 6'd27);
    d_ins = enc(5'h11, 5'd0, 10'h2AA, 6'd27);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: zero operand, zero word
    apply(32'd0, 64'd0, "R9 reset");
    // R2 NaNs
    apply(s_ins, 64'h0000_0000_7F80_0001, "R2 single sNaN");
    apply(s_ins, 64'h0000_0000_FFC0_0000, "R2 single qNaN neg");
    apply(d_ins, 64'h7FF0_0000_0000_0001, "R2 double sNaN");
    apply(d_ins, 64'hFFF8_0000_0000_0000, "R2 double qNaN neg");
    // R3 infinities
    apply(s_ins, 64'h0000_0000_FF80_0000, "R3 single -inf");
    apply(d_ins, 64'h7FF0_0000_0000_0000, "R3 double +inf");
    // R4 zeros
    apply(s_ins, 64'h0000_0000_8000_0000, "R4 single -0");
    apply(d_ins, 64'h0000_0000_0000_0000, "R4 double +0");
    // R5 subnormals
    apply(s_ins, 64'h0000_0000_807F_FFFF, "R5 single -sub");
    apply(d_ins, 64'h0000_0000_0000_0001, "R5 double +sub");
    // R6 normals at boundaries
    apply(s_ins, 64'h0000_0000_0080_0000, "R6 single +min normal");
    apply(d_ins, 64'hFFEF_FFFF_FFFF_FFFF, "R6 double -max normal");
    // R7 upper half ignored in single
    apply(s_ins, 64'h7FF8_0000_3F80_0000, "R7 single ignores upper");
    apply(s_ins, 64'hFFFF_FFFF_0000_0000, "R7 single ignores upper zero");
    apply(d_ins, 64'h0000_0000_7F80_0000, "R7 double wide field");
    // R8 encoding checks
    apply(enc(5'h10, 5'd1, 10'h0, 6'd27), 64'h3F80_0000, "R8 ft nonzero");
    apply(enc(5'h11, 5'h10, 10'h0, 6'd27), 64'h3F80_0000, "R8 ft msb set");
    apply(enc(5'h14, 5'd0, 10'h0, 6'd27), 64'h3F80_0000, "R8 bad fmt");
    apply(enc(5'h10, 5'd0, 10'h0, 6'd26), 64'h3F80_0000, "R8 bad func");
    apply({6'h10, 5'h10, 5'd0, 10'h0, 6'd27}, 64'h3F80_0000, "R8 bad major");
    apply(enc(5'h11, 5'd0, 10'h3FF, 6'd27), 64'hBFF0_0000_0000_0000, "R8 mid bits free");
    // R1 mixed sweep
    for (int i = 0; i < 400; i++) begin
      logic [63:0] v;
      logic [4:0] fmt;
      v = {$urandom, $urandom};
      fmt = i[0] ? 5'h11 : 5'h10;
      case (i % 5)
        0: begin v[62:52] = 11'h7FF; v[30:23] = 8'hFF; end
        1: begin v[62:52] = 11'h000; v[30:23] = 8'h00; end
        2: begin v[51:0] = 52'd0; v[22:0] = 23'd0; end
        default: ;
      endcase
      apply(enc(fmt, (i % 17 == 0) ? 5'd3 : 5'd0, $urandom, 6'd27), v, "R1 sweep");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule